// File: doc/BRIEF.md
# Programmable Edge Interrupt Detector

This block watches a set of asynchronous external interrupt pins and turns each qualifying transition into a request pulse that is exactly one clock wide. Each pin has its own 2-bit edge code, so it can react to falling edges, rising edges or both. One code value is reserved and keeps the pin silent. The codes are held in byte-wide configuration registers on a small bus. A bus write either replaces a whole byte or forces one addressed bit to a given value.

Two of the pins also act as external start inputs for an A/D converter. For those pins the same edge code also qualifies a second pulse on a separate trigger output. That pulse is only issued while the matching trigger-mode enable input is high. The interrupt pulse for the same pin is issued whatever the enable says.

The path from each pin goes through a two-flop synchronizer and then a registered compare against the previous synchronized value. A pin change is therefore seen as a pulse on the third rising clock edge after it.

Top module: `ext_edge_irq`

## Requirements
- R1: Edge code 00 (falling) on a pin produces a pulse on its `irq_o` bit only for a 1-to-0 transition of that pin.
- R2: Edge code 01 (rising) produces a pulse only for a 0-to-1 transition.
- R3: Edge code 11 (both) produces a pulse for every transition, including transitions on consecutive clock cycles.
- R4: Edge code 10 is reserved. It produces no interrupt pulse and no trigger pulse for any transition, and it reads back exactly as written.
- R5: Pins 0 to 3 take their codes from the register at offset 0, with pin n in bits 2n+1:2n. Pins 4 to 6 take theirs from the register at offset 2, with pin 4 in bits 1:0, pin 5 in bits 3:2 and pin 6 in bits 5:4. Bits 7:6 at offset 2 always read 0 and ignore writes. Odd offsets read 0 and ignore writes.
- R6: After reset both registers read 00h. Every pin then reacts to falling edges only.
- R7: A write with `bus_bitop_i` high changes only bit `bus_bidx_i` of the addressed register, setting it to `bus_bval_i`.
- R8: A pin change driven before clock edge N shows as an `irq_o` pulse that is high from edge N+2 to edge N+3. The pulse is one cycle wide, and no pulse appears without a qualifying change.
- R9: `trig_o[0]` follows pin 2 and `trig_o[1]` follows pin 3. Each uses the same edge code and the same timing as that pin's interrupt pulse. It is high only when `trig_en_i[k]` is high at the edge that registers the pulse. The interrupt pulses of pins 2 and 3 do not depend on `trig_en_i`.
- R10: Each pin's code acts only on that pin. Pins with different codes that switch in the same cycle each follow their own code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pins_i | input | 7 | Asynchronous external interrupt pins |
| trig_en_i | input | 2 | A/D trigger-mode enables for pins 2 and 3 |
| bus_wr_i | input | 1 | Register write strobe |
| bus_bitop_i | input | 1 | 1: single-bit write, 0: whole-byte write |
| bus_addr_i | input | 2 | Register byte offset |
| bus_bidx_i | input | 3 | Bit index for single-bit writes |
| bus_bval_i | input | 1 | Value for single-bit writes |
| bus_wdata_i | input | 8 | Byte write data |
| bus_rdata_o | output | 8 | Read data for `bus_addr_i` (combinational) |
| irq_o | output | 7 | One-cycle interrupt request pulses |
| trig_o | output | 2 | One-cycle A/D trigger pulses |

## Verification
The bench builds the block with its defaults: seven pins, byte-wide registers, two trigger pins starting at pin 2, and a two-stage synchronizer. With these values the partly filled second register and its always-zero top bits can be reached, and so can the odd and out-of-range offsets. Under this shape the trigger routing of exactly pins 2 and 3 is checked cycle by cycle against the fixed three-edge latency.

// File: rtl/eei_pkg.sv
package eei_pkg;

    typedef enum logic [1:0] {
        EDGE_FALL = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_RSVD = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_sel_e;

    localparam int SEL_W = 2;

endpackage

// File: rtl/eei_sync.sv
module eei_sync #(
    parameter int WIDTH  = 7,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stg_d [STAGES];
    logic [WIDTH-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            stg_d[s] = stg_q[s-1];
        end
    end

    always_ff @(posedge clk) begin
        for (int s = 0; s < STAGES; s++) begin
            if (!rst_n) stg_q[s] <= '0;
            else        stg_q[s] <= stg_d[s];
        end
    end

    assign sync_o = stg_q[STAGES-1];

endmodule

// File: rtl/eei_edge_det.sv
module eei_edge_det
    import eei_pkg::*;
#(
    parameter int WIDTH = 7,
    localparam int MODE_W = WIDTH * SEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WIDTH-1:0]  sync_i,
    input  logic [MODE_W-1:0] mode_i,
    output logic [WIDTH-1:0]  hit_o,
    output logic [WIDTH-1:0]  pulse_o
);

    typedef struct packed {
        logic [WIDTH-1:0] prev;
        logic [WIDTH-1:0] pulse;
    } det_t;

    det_t det_d, det_q;
    logic [WIDTH-1:0] rise, fall, hit;

    always_comb begin
        rise = sync_i & ~det_q.prev;
        fall = ~sync_i & det_q.prev;
        for (int i = 0; i < WIDTH; i++) begin
            case (edge_sel_e'(mode_i[SEL_W*i +: SEL_W]))
                EDGE_FALL: hit[i] = fall[i];
                EDGE_RISE: hit[i] = rise[i];
                EDGE_BOTH: hit[i] = rise[i] | fall[i];
                default:   hit[i] = 1'b0;
            endcase
        end
        det_d.prev  = sync_i;
        det_d.pulse = hit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) det_q <= '0;
        else        det_q <= det_d;
    end

    assign hit_o   = hit;
    assign pulse_o = det_q.pulse;

    for (genvar i = 0; i < WIDTH; i++) begin : g_chk
        // R8: a pulse requires that the synchronized input changed one edge earlier
        p_pulse_on_change_r8: assert property (@(posedge clk) disable iff (!rst_n)
            det_q.pulse[i] |-> ($past(sync_i[i]) != $past(sync_i[i], 2)));
    end

endmodule

// File: rtl/eei_regs.sv
module eei_regs
    import eei_pkg::*;
#(
    parameter int NUM_PINS = 7,
    parameter int DATA_W   = 8,
    localparam int BITS    = NUM_PINS * SEL_W,
    localparam int REG_CNT = (BITS + DATA_W - 1) / DATA_W,
    localparam int TOT     = REG_CNT * DATA_W,
    localparam int ADDR_W  = (REG_CNT > 1) ? $clog2(2 * REG_CNT) : 1,
    localparam int IDX_W   = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_bitop,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [IDX_W-1:0]  bus_bidx,
    input  logic              bus_bval,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [BITS-1:0]   mode_o
);

    function automatic logic [TOT-1:0] impl_mask();
        logic [TOT-1:0] m;
        for (int b = 0; b < TOT; b++) m[b] = (b < BITS);
        return m;
    endfunction

    localparam logic [TOT-1:0] IMPL = impl_mask();

    typedef struct packed {
        logic [TOT-1:0] cfg;
    } regs_t;

    regs_t regs_d, regs_q;
    int unsigned ridx;
    logic addr_ok;
    logic [DATA_W-1:0] cur, nxt;

    always_comb begin
        ridx    = 32'(bus_addr) >> 1;
        addr_ok = !bus_addr[0] && (ridx < REG_CNT);
        cur     = '0;
        nxt     = '0;
        regs_d  = regs_q;
        if (addr_ok) cur = regs_q.cfg[ridx*DATA_W +: DATA_W];
        if (bus_wr && addr_ok) begin
            if (bus_bitop) begin
                nxt           = cur;
                nxt[bus_bidx] = bus_bval;
            end else begin
                nxt = bus_wdata;
            end
            regs_d.cfg[ridx*DATA_W +: DATA_W] = nxt;
        end
        regs_d.cfg = regs_d.cfg & IMPL;
        bus_rdata  = cur;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign mode_o = regs_q.cfg[BITS-1:0];

    // R7: a single-bit write alters at most one stored bit
    p_bit_write_local_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_bitop) |=> ($countones(regs_q.cfg ^ $past(regs_q.cfg)) <= 1));

    // R5: writes to odd or absent offsets leave the configuration untouched
    p_bad_addr_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !addr_ok) |=> $stable(regs_q.cfg));

    // R5: bits with no pin behind them never read as one
    p_unimpl_read_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_ok && ridx == REG_CNT - 1) |->
            ((bus_rdata & ~IMPL[(REG_CNT-1)*DATA_W +: DATA_W]) == '0));

endmodule

// File: rtl/ext_edge_irq.sv
module ext_edge_irq
    import eei_pkg::*;
#(
    parameter int NUM_PINS    = 7,
    parameter int DATA_W      = 8,
    parameter int NUM_TRIG    = 2,
    parameter int TRIG_BASE   = 2,
    parameter int SYNC_STAGES = 2,
    localparam int BITS       = NUM_PINS * SEL_W,
    localparam int REG_CNT    = (BITS + DATA_W - 1) / DATA_W,
    localparam int ADDR_W     = (REG_CNT > 1) ? $clog2(2 * REG_CNT) : 1,
    localparam int IDX_W      = $clog2(DATA_W)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pins_i,
    input  logic [NUM_TRIG-1:0] trig_en_i,
    input  logic                bus_wr_i,
    input  logic                bus_bitop_i,
    input  logic [ADDR_W-1:0]   bus_addr_i,
    input  logic [IDX_W-1:0]    bus_bidx_i,
    input  logic                bus_bval_i,
    input  logic [DATA_W-1:0]   bus_wdata_i,
    output logic [DATA_W-1:0]   bus_rdata_o,
    output logic [NUM_PINS-1:0] irq_o,
    output logic [NUM_TRIG-1:0] trig_o
);

    logic [NUM_PINS-1:0] pin_sync;
    logic [NUM_PINS-1:0] hit;
    logic [BITS-1:0]     mode;

    typedef struct packed {
        logic [NUM_TRIG-1:0] trig;
    } top_t;

    top_t top_d, top_q;

    eei_regs #(.NUM_PINS(NUM_PINS), .DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr_i),
        .bus_bitop (bus_bitop_i),
        .bus_addr  (bus_addr_i),
        .bus_bidx  (bus_bidx_i),
        .bus_bval  (bus_bval_i),
        .bus_wdata (bus_wdata_i),
        .bus_rdata (bus_rdata_o),
        .mode_o    (mode)
    );

    eei_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pins_i),
        .sync_o  (pin_sync)
    );

    eei_edge_det #(.WIDTH(NUM_PINS)) u_det (
        .clk     (clk),
        .rst_n   (rst_n),
        .sync_i  (pin_sync),
        .mode_i  (mode),
        .hit_o   (hit),
        .pulse_o (irq_o)
    );

    always_comb begin
        top_d.trig = hit[TRIG_BASE +: NUM_TRIG] & trig_en_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    assign trig_o = top_q.trig;

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin_chk
        // R4: the reserved code never lets a request out
        p_reserved_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
            irq_o[i] |-> ($past(mode[SEL_W*i +: SEL_W]) != EDGE_RSVD));
    end

    for (genvar k = 0; k < NUM_TRIG; k++) begin : g_trig_chk
        // R9: a trigger pulse always coincides with its pin's interrupt pulse
        p_trig_with_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
            trig_o[k] |-> irq_o[TRIG_BASE + k]);
        // R9: no trigger pulse unless its enable was high when it was registered
        p_trig_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
            trig_o[k] |-> $past(trig_en_i[k]));
    end

endmodule

// File: tb/ext_edge_irq_tb.sv
module ext_edge_irq_tb;

    typedef struct {
        int       cyc;
        logic [6:0] irq;
        logic [1:0] trig;
        string    tag;
    } item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] pins = '0;
    logic [1:0] trig_en = '0;
    logic       wr = 1'b0, bitop = 1'b0, bval = 1'b0;
    logic [1:0] addr = '0;
    logic [2:0] bidx = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [6:0] irq;
    logic [1:0] trig;

    int checks = 0, fails = 0, cyc = 0;
    bit monitor_on = 1'b0;
    item_t sb[$];
    logic [7:0] sh0 = '0, sh1 = '0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    ext_edge_irq u_dut (
        .clk(clk), .rst_n(rst_n), .pins_i(pins), .trig_en_i(trig_en),
        .bus_wr_i(wr), .bus_bitop_i(bitop), .bus_addr_i(addr),
        .bus_bidx_i(bidx), .bus_bval_i(bval), .bus_wdata_i(wdata),
        .bus_rdata_o(rdata), .irq_o(irq), .trig_o(trig)
    );

    function automatic logic [1:0] pin_code(int p);
        return (p < 4) ? sh0[2*p +: 2] : sh1[2*(p-4) +: 2];
    endfunction

    function automatic logic hit_of(logic [1:0] c, logic o, logic n);
        case (c)
            2'b00:   return o & ~n;
            2'b01:   return ~o & n;
            2'b11:   return o ^ n;
            default: return 1'b0;
        endcase
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // driver: change pins, push the expected pulses three edges later
    task automatic drive(logic [6:0] v, string tag);
        item_t it;
        @(negedge clk);
        it.cyc = cyc + 3;
        for (int p = 0; p < 7; p++) it.irq[p] = hit_of(pin_code(p), pins[p], v[p]);
        it.trig = it.irq[3:2] & trig_en;
        it.tag  = tag;
        sb.push_back(it);
        pins = v;
    endtask

    task automatic settle();
        repeat (5) @(negedge clk);
    endtask

    task automatic wr_byte(logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        wr = 1'b1; bitop = 1'b0; addr = a; wdata = d;
        if (a == 2'd0) sh0 = d;
        if (a == 2'd2) sh1 = d & 8'h3F;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic wr_bit(logic [1:0] a, logic [2:0] i, logic v);
        @(negedge clk);
        wr = 1'b1; bitop = 1'b1; addr = a; bidx = i; bval = v;
        if (a == 2'd0) sh0[i] = v;
        if (a == 2'd2 && i < 3'd6) sh1[i] = v;
        @(negedge clk);
        wr = 1'b0; bitop = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, logic [7:0] exp, string tag);
        @(negedge clk);
        addr = a;
        #1;
        check(tag, 32'(rdata), 32'(exp));
    endtask

    // monitor: compares outputs every cycle against the scoreboard
    always @(negedge clk) begin
        if (monitor_on) begin
            if (sb.size() > 0 && sb[0].cyc <= cyc) begin
                item_t it;
                it = sb.pop_front();
                if (it.cyc != cyc) check({it.tag, " missed slot"}, 32'(cyc), 32'(it.cyc));
                check({it.tag, " irq"}, 32'(irq), 32'(it.irq));
                check({it.tag, " trig"}, 32'(trig), 32'(it.trig));
            end else begin
                check("R8 idle irq", 32'(irq), 32'd0);
                check("R8 idle trig", 32'(trig), 32'd0);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R6 reset state
        rd(2'd0, 8'h00, "R6 reg0 reset");
        rd(2'd2, 8'h00, "R6 reg2 reset");
        @(negedge clk);
        monitor_on = 1'b1;
        drive(7'h7F, "R6 rise ignored by default");
        settle();
        drive(7'h00, "R1 falling all pins");
        settle();
        // R5 layout: pin0 fall, pin1 rise, pin2 reserved, pin3 both; pins 4-6 both
        wr_byte(2'd0, 8'hE4);
        wr_byte(2'd2, 8'hFF);
        rd(2'd0, 8'hE4, "R4 reg0 readback");
        rd(2'd2, 8'h3F, "R5 reg2 top bits zero");
        trig_en = 2'b11;
        drive(7'h7F, "R10 mixed codes rise");
        settle();
        drive(7'h00, "R10 mixed codes fall");
        settle();
        // R7 single-bit writes
        wr_bit(2'd0, 3'd4, 1'b1);
        rd(2'd0, 8'hF4, "R7 set bit4");
        wr_bit(2'd0, 3'd7, 1'b0);
        rd(2'd0, 8'h74, "R7 clear bit7");
        wr_bit(2'd2, 3'd1, 1'b0);
        rd(2'd2, 8'h3D, "R7 clear reg2 bit1");
        // R9 trigger gating: pin2 both, pin3 rise
        trig_en = 2'b01;
        drive(7'h0C, "R9 trig pin2 enabled");
        settle();
        drive(7'h00, "R9 pin2 fall pin3 silent");
        settle();
        trig_en = 2'b00;
        drive(7'h04, "R9 irq without trig");
        settle();
        drive(7'h00, "R9 irq without trig fall");
        settle();
        // R4 reserved everywhere
        trig_en = 2'b11;
        wr_byte(2'd0, 8'hAA);
        wr_byte(2'd2, 8'h2A);
        rd(2'd0, 8'hAA, "R4 reg0 reserved readback");
        rd(2'd2, 8'h2A, "R4 reg2 reserved readback");
        drive(7'h7F, "R4 reserved rise");
        settle();
        drive(7'h00, "R4 reserved fall");
        settle();
        // R5 ignored writes
        wr_byte(2'd1, 8'hFF);
        wr_byte(2'd3, 8'h55);
        wr_bit(2'd2, 3'd7, 1'b1);
        rd(2'd0, 8'hAA, "R5 odd write ignored");
        rd(2'd2, 8'h2A, "R5 reg2 bit7 ignored");
        rd(2'd1, 8'h00, "R5 odd offset reads zero");
        rd(2'd3, 8'h00, "R5 offset3 reads zero");
        // R2 rising only
        wr_byte(2'd0, 8'h55);
        wr_byte(2'd2, 8'h15);
        drive(7'h5A, "R2 rising pattern");
        settle();
        drive(7'h00, "R2 falling ignored");
        settle();
        // R3/R8 back-to-back transitions in both-edge mode
        wr_byte(2'd0, 8'hFF);
        wr_byte(2'd2, 8'h3F);
        drive(7'h01, "R3 toggle 1");
        drive(7'h00, "R3 toggle 2");
        drive(7'h41, "R8 toggle 3");
        settle();
        drive(7'h00, "R3 return low");
        settle();
        monitor_on = 1'b0;
        check("R8 scoreboard drained", 32'(sb.size()), 32'd0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule